// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

After reset this block runs the power-up sequence that a bank of SDRAM needs before it can hold data, entirely on its own. It drives a three-bit command-mode field and a one-cycle dummy-read strobe with an address into the memory command controller above it. The controller turns each strobe into the command selected by the mode field. The sequence is: a no-operation command followed by a 200 us settling wait, a precharge of all banks, eight auto-refresh rounds, a load of the mode register, and then normal refresh. Every command goes to the first row at address zero. If the row-offset input is non-zero, the same command also goes to the second row at that offset.

All waits are counted in clock cycles. Each count is derived from the `CLK_KHZ` parameter and rounded up to a whole cycle, so no wait is ever shorter than its time budget. Until the sequence completes, `busy` is high and host memory requests get no acknowledge. Once normal refresh is selected, `done` rises and stays high until the next reset. A reset at any point restarts the sequence from its first step.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, the mode field is 0 (refresh off), there is no strobe, `done` is 0 and `busy` is 1. Any reset, including one in the middle of the sequence, restarts the sequence from the no-operation step.
- R2: One cycle after reset is released, the no-operation step (mode 4) strobes address 0. It then waits ceil(200 us × f) cycles, where f is the clock rate set by `CLK_KHZ`.
- R3: The precharge-all step (mode 5) strobes its row(s) and then waits ceil(1 us × f) cycles.
- R4: The refresh step (mode 7) repeats eight rounds. Each round strobes its row(s) and then waits ceil(1 us × f) cycles.
- R5: The mode-register step (mode 6) strobes address 0x1D0, and also row_offset + 0x1D0 when the offset is non-zero. It then waits ceil(2 us × f) cycles.
- R6: After the mode-register wait, the mode field becomes 1 (normal refresh) for one cycle with no strobe. On the next cycle `done` rises. From then until reset, `done` stays 1, the mode stays 1 and there are no strobes.
- R7: With a non-zero row offset, each step strobes address base on one cycle and row_offset + base on the next cycle. With a zero offset, only the base address is strobed and the second cycle is skipped.
- R8: Each wait lasts exactly the number of cycles in R2, R3 or R5. The count is rounded up whenever the product is not a whole number of cycles.
- R9: `busy` is the inverse of `done`. `host_ack` is high only when `host_req` and `done` are both high.
- R10: A strobe lasts one cycle per row address, and strobes occur only while the mode is 4, 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_offset | input | AW | Base address of the second row; 0 when only one row is fitted |
| host_req | input | 1 | Host memory request |
| host_ack | output | 1 | Request accepted; high only after initialization |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Memory is in normal operation |
| dram_mode | output | 3 | Command mode for the controller: 0 off, 1 normal, 4 NOP, 5 precharge, 6 mode set, 7 refresh |
| dummy_rd | output | 1 | Dummy-read strobe that issues the selected command |
| dummy_addr | output | AW | Address of the dummy read |

## Verification
Counting from the first rising edge after reset is released, the first strobe is due in cycle 1. Each later strobe is due at the previous step's start plus its row count plus its rounded wait. `done` is due exactly one cycle after the cycle in which normal mode appears. The bench builds the full list of expected strobe cycles, modes and addresses up front from these sums. Using a clock rate that makes the 1 us and 2 us budgets fractional, it compares every strobe against that list, sampling on the falling edge. It checks the `done` cycle and the reset outputs at the same falling-edge points.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NOP, ST_PRE, ST_CBR, ST_MRS, ST_NORM, ST_DONE
  } step_e;

  typedef enum logic [1:0] {
    PH_ROW0, PH_ROW1, PH_WAIT
  } phase_e;

  localparam logic [2:0] MODE_OFF    = 3'd0;
  localparam logic [2:0] MODE_NORMAL = 3'd1;
  localparam logic [2:0] MODE_NOP    = 3'd4;
  localparam logic [2:0] MODE_PRE    = 3'd5;
  localparam logic [2:0] MODE_MRS    = 3'd6;
  localparam logic [2:0] MODE_CBR    = 3'd7;

  localparam int MRS_VALUE = 'h1D0;

  // cycles covering a budget of 'us' microseconds at 'khz', rounded up
  function automatic int wait_cycles(input int us, input int khz);
    return (us * khz + 999) / 1000;
  endfunction

  function automatic logic [2:0] step_mode(input step_e s);
    case (s)
      ST_NOP:  return MODE_NOP;
      ST_PRE:  return MODE_PRE;
      ST_CBR:  return MODE_CBR;
      ST_MRS:  return MODE_MRS;
      ST_NORM, ST_DONE: return MODE_NORMAL;
      default: return MODE_OFF;
    endcase
  endfunction

  function automatic logic is_cmd(input step_e s);
    return (s == ST_NOP) || (s == ST_PRE) || (s == ST_CBR) || (s == ST_MRS);
  endfunction

  function automatic step_e step_after(input step_e s);
    case (s)
      ST_NOP:  return ST_PRE;
      ST_PRE:  return ST_CBR;
      ST_CBR:  return ST_MRS;
      ST_MRS:  return ST_NORM;
      default: return ST_DONE;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          active,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expired = active && (cnt == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CW        = 8,
  parameter int W_INIT    = 200,
  parameter int W_GAP     = 1,
  parameter int W_MRS     = 2,
  parameter int CBR_COUNT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          two_rows,
  input  logic          wait_expired,
  output step_e         step,
  output phase_e        phase,
  output logic          wait_load,
  output logic [CW-1:0] wait_val
);
  localparam int RW = (CBR_COUNT > 1) ? $clog2(CBR_COUNT) : 1;
  localparam logic [RW-1:0] LAST_ROUND = RW'(CBR_COUNT - 1);

  logic [RW-1:0] round;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step  <= ST_IDLE;
      phase <= PH_ROW0;
      round <= '0;
    end else begin
      case (phase)
        PH_ROW0: begin
          case (step)
            ST_IDLE: step <= ST_NOP;
            ST_NORM: step <= ST_DONE;
            ST_DONE: step <= ST_DONE;
            default: phase <= two_rows ? PH_ROW1 : PH_WAIT;
          endcase
        end
        PH_ROW1: phase <= PH_WAIT;
        PH_WAIT: begin
          if (wait_expired) begin
            phase <= PH_ROW0;
            if (step == ST_CBR && round != LAST_ROUND) begin
              round <= round + 1'b1;
            end else begin
              round <= '0;
              step  <= step_after(step);
            end
          end
        end
        default: phase <= PH_ROW0;
      endcase
    end
  end

  // timer is loaded on the last strobe cycle of a step
  assign wait_load = (phase == PH_ROW1) ||
                     (phase == PH_ROW0 && is_cmd(step) && !two_rows);

  always_comb begin
    case (step)
      ST_NOP:  wait_val = CW'(W_INIT - 1);
      ST_MRS:  wait_val = CW'(W_MRS - 1);
      default: wait_val = CW'(W_GAP - 1);
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_KHZ   = 100000,
  parameter int AW        = 28,
  parameter int CBR_COUNT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] row_offset,
  input  logic          host_req,
  output logic          host_ack,
  output logic          busy,
  output logic          done,
  output logic [2:0]    dram_mode,
  output logic          dummy_rd,
  output logic [AW-1:0] dummy_addr
);
  localparam int W_INIT = wait_cycles(200, CLK_KHZ);
  localparam int W_GAP  = wait_cycles(1, CLK_KHZ);
  localparam int W_MRS  = wait_cycles(2, CLK_KHZ);
  localparam int CW     = $clog2(W_INIT + 1);

  step_e         step;
  phase_e        phase;
  logic          wait_load;
  logic [CW-1:0] wait_val;
  logic          wait_active;
  logic          wait_expired;
  logic          two_rows;

  assign two_rows = (row_offset != '0);

  sdram_init_fsm #(
    .CW(CW), .W_INIT(W_INIT), .W_GAP(W_GAP), .W_MRS(W_MRS),
    .CBR_COUNT(CBR_COUNT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .two_rows(two_rows),
    .wait_expired(wait_expired), .step(step), .phase(phase),
    .wait_load(wait_load), .wait_val(wait_val)
  );

  sdram_init_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(wait_load), .load_val(wait_val),
    .active(wait_active), .expired(wait_expired)
  );

  logic [AW-1:0] row_base;
  logic [AW-1:0] cmd_base;

  assign row_base   = (phase == PH_ROW1) ? row_offset : '0;
  assign cmd_base   = (step == ST_MRS) ? AW'(MRS_VALUE) : '0;
  assign dram_mode  = step_mode(step);
  assign dummy_rd   = is_cmd(step) && (phase != PH_WAIT);
  assign dummy_addr = row_base + cmd_base;
  assign done       = (step == ST_DONE);
  assign busy       = !done;
  assign host_ack   = host_req && done;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int CLK_KHZ = 100000,
  parameter int AW      = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] row_offset,
  input logic          host_req,
  input logic          host_ack,
  input logic          busy,
  input logic          done,
  input logic [2:0]    dram_mode,
  input logic          dummy_rd,
  input logic [AW-1:0] dummy_addr,
  input logic          wait_active,
  input logic          wait_expired
);
  localparam int W_INIT = (200 * CLK_KHZ + 999) / 1000;
  localparam int W_GAP  = (CLK_KHZ + 999) / 1000;
  localparam int W_MRS  = (2 * CLK_KHZ + 999) / 1000;

  int wcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wcnt <= 0;
    else if (wait_active) wcnt <= wcnt + 1;
    else                  wcnt <= 0;
  end

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_quiet_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!dummy_rd && dram_mode == 3'd1));

  assert_strobe_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_rd |-> dram_mode[2]);

  assert_single_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy_rd && row_offset == '0) |-> (dummy_addr == '0 || dummy_addr == AW'(32'h1D0)));

  assert_wait_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_expired |-> (wcnt == W_INIT - 1 || wcnt == W_GAP - 1 || wcnt == W_MRS - 1));

  assert_no_strobe_in_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wait_active |-> !dummy_rd);

  assert_host_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> (done && host_req && !busy));
endmodule

bind sdram_init_seq sdram_init_chk #(.CLK_KHZ(CLK_KHZ), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_offset(row_offset), .host_req(host_req),
  .host_ack(host_ack), .busy(busy), .done(done), .dram_mode(dram_mode),
  .dummy_rd(dummy_rd), .dummy_addr(dummy_addr),
  .wait_active(wait_active), .wait_expired(wait_expired)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;
  localparam int AW      = 28;
  localparam int CLK_KHZ = 12345;
  // 200 us -> 2469 cycles exactly; 1 us -> 12.345 -> 13; 2 us -> 24.69 -> 25
  localparam int T_INIT = 2469;
  localparam int T_GAP  = 13;
  localparam int T_MRS  = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] row_offset = '0;
  logic          host_req = 1'b1;
  logic          host_ack, busy, done, dummy_rd;
  logic [2:0]    dram_mode;
  logic [AW-1:0] dummy_addr;

  always #4 clk = ~clk;

  sdram_init_seq #(.CLK_KHZ(CLK_KHZ), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .row_offset(row_offset), .host_req(host_req),
    .host_ack(host_ack), .busy(busy), .done(done), .dram_mode(dram_mode),
    .dummy_rd(dummy_rd), .dummy_addr(dummy_addr)
  );

  typedef struct {
    int            t;
    logic [2:0]    mode;
    logic [AW-1:0] addr;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  function automatic void push_step(input int t, input logic [2:0] mode,
                                    input logic [AW-1:0] base, input logic [AW-1:0] off);
    q.push_back('{t, mode, base});
    if (off != '0) q.push_back('{t + 1, mode, off + base});
  endfunction

  // monitor: pops one expected entry per observed strobe
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) cyc = 0;
      else begin
        cyc++;
        if (dummy_rd) begin
          if (q.size() == 0)
            chk(1'b0, "R10", $sformatf("strobe at cycle %0d", cyc), "no strobe");
          else begin
            exp_t e;
            e = q.pop_front();
            chk(cyc == e.t && dram_mode == e.mode && dummy_addr == e.addr, "R2-R5/R7",
                $sformatf("t=%0d mode=%0d addr=%h", cyc, dram_mode, dummy_addr),
                $sformatf("t=%0d mode=%0d addr=%h", e.t, e.mode, e.addr));
          end
        end
      end
    end
  end

  task automatic check_reset_outputs();
    chk(dram_mode == 3'd0 && !dummy_rd && !done && busy && !host_ack, "R1",
        $sformatf("mode=%0d rd=%0b done=%0b busy=%0b", dram_mode, dummy_rd, done, busy),
        "mode=0 rd=0 done=0 busy=1");
  endtask

  // driver: pushes the expected strobe list, runs one sequence
  task automatic run(input logic [AW-1:0] off, input int abort_at);
    int r;
    int t;
    int t_norm;
    int k;
    r = (off != '0) ? 2 : 1;
    q.delete();
    row_offset = off;
    t = 1;
    push_step(t, 3'd4, '0, off);            t += r + T_INIT;   // R2
    push_step(t, 3'd5, '0, off);            t += r + T_GAP;    // R3
    for (int i = 0; i < 8; i++) begin                         // R4
      push_step(t, 3'd7, '0, off);          t += r + T_GAP;
    end
    push_step(t, 3'd6, AW'(32'h1D0), off);  t += r + T_MRS;    // R5
    t_norm = t;
    @(negedge clk); #2 rst_n = 1'b1;
    k = 0;
    while (k < 4000) begin
      @(negedge clk);
      k++;
      if (abort_at != 0 && k == abort_at) break;
      if (k == 5)
        chk(!host_ack && busy, "R9", $sformatf("ack=%0b busy=%0b", host_ack, busy), "ack=0 busy=1");
      if (k == t_norm)
        chk(dram_mode == 3'd1 && !done && !dummy_rd, "R6",
            $sformatf("mode=%0d done=%0b rd=%0b", dram_mode, done, dummy_rd), "mode=1 done=0 rd=0");
      if (done) break;
    end
    if (abort_at != 0) begin
      #2 rst_n = 1'b0;
      #1 check_reset_outputs();                                 // R1 mid-sequence
      q.delete();
    end else begin
      chk(k == t_norm + 1, "R6", $sformatf("done at %0d", k), $sformatf("done at %0d", t_norm + 1));
      chk(q.size() == 0, "R7", $sformatf("%0d strobes missing", q.size()), "0 missing");
      chk(host_ack && !busy, "R9", $sformatf("ack=%0b busy=%0b", host_ack, busy), "ack=1 busy=0");
      repeat (20) @(negedge clk);
      chk(done && dram_mode == 3'd1, "R6", $sformatf("done=%0b mode=%0d", done, dram_mode), "done=1 mode=1");
      host_req = 1'b0;
      @(negedge clk);
      chk(!host_ack, "R9", $sformatf("ack=%0b", host_ack), "ack=0");
      host_req = 1'b1;
      #2 rst_n = 1'b0;
      #1 check_reset_outputs();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_outputs();                                      // R1
    run(AW'(32'h0200000), 2500);   // abort during refresh rounds, R1 restart
    run(AW'(32'h0200000), 0);      // two rows, R8 rounded waits
    run('0, 0);                    // single row, R7
    run(AW'(32'h0400000), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule